// File: doc/BRIEF.md
# Clock Multiplier Settings and Lock Controller

This block sits between a simple register bus and an analog clock-multiplier loop. Software writes a multiplier, a pre-divider, an enable bit and a connect bit into pending registers. Those values have no effect on the loop until a two-write unlock sequence reaches a dedicated key register. That sequence copies every pending value into the active set at once. A read-only status word reports only the active set, so software can tell what the loop is actually running with.

The block qualifies the loop's lock indication before reporting it. While the reference frequency is in the trusted band, the lock flag follows the loop's own lock input. Outside that band, the flag is raised by a start-up timer. The timer counts system-clock cycles when the reference is fast, and reference-clock rising edges when the reference is slow. Any change to the active multiplier, divider or enable restarts lock acquisition. The lock flag also serves as a level interrupt request. A power-down request forces the loop off and bypassed. The multiplied clock is selected only while the active enable and the active connect are both set.

Top module: `clkmul_ctrl`

## Requirements
- R1: After a synchronous reset, all pending and active settings, the status word, `rdata`, `pll_sel` and `lock_irq` are zero.
- R2: Writes to the control register (address 0: bit 0 enable, bit 1 connect) and to the configuration register (address 1: bits 14:0 multiplier minus one, bits 23:16 divider minus one) change only the pending values. Reading either address returns the last written fields, with all other bits zero. Active values and the status word do not change.
- R3: Two writes to the key register (address 2) commit all pending values to the active set. The first write must carry 0xAA in its low byte and the second 0x55, with no other bus write between them. A wrong byte, or any intervening write to any address, abandons the sequence and leaves the active set unchanged. A key write of 0xAA always starts a new sequence.
- R4: The status word (address 3) packs the active fields as follows: multiplier in bits 14:0, divider in bits 23:16, enable in bit 24, connect in bit 25 and lock in bit 26. Bits 15 and 31:27 read zero.
- R5: `pll_sel` is high exactly when the active enable and the active connect are both one.
- R6: A cycle with `pwr_down_req` high clears the active enable and connect at that clock edge, even when a commit lands in the same cycle. Pending values are kept.
- R7: With `ref_range` = 0 and the loop enabled, the lock flag equals `lock_in` sampled at the previous edge. While the active enable is zero, the lock flag is zero.
- R8: With `ref_range` = 1, the lock flag rises exactly `START_CYC` clock edges after the edge that (re)started acquisition, and then stays high.
- R9: With `ref_range` = 2 or 3, the lock flag rises after `REF_CYC` rising edges of `ref_clk` have been counted since acquisition restarted. Edges are counted after a synchronizer.
- R10: A commit or power-down that changes the active multiplier, divider or enable clears the lock flag at that edge and restarts acquisition. A commit that leaves those three unchanged does not disturb the lock.
- R11: Writes to the status address change nothing. The key register reads as zero.
- R12: `lock_irq` is a level output equal to status bit 26 and stays high as long as the lock flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe; `rdata` updates at the next edge |
| addr | input | 2 | Register select: 0 control, 1 configuration, 2 key, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwr_down_req | input | 1 | Power-down request, clears active enable and connect |
| ref_range | input | 2 | 0 reference in trusted band, 1 out of band and fast, 2/3 out of band and slow |
| ref_clk | input | 1 | Reference clock, sampled through a synchronizer |
| lock_in | input | 1 | Lock indication from the analog loop |
| pll_sel | output | 1 | Multiplied clock selected as CPU clock |
| lock_irq | output | 1 | Level lock interrupt request |
| act_mult | output | 15 | Active multiplier field (value minus one) |
| act_div | output | 8 | Active divider field (value minus one) |

## Verification
The assertions check several properties on every cycle. Active settings and `pll_sel` hold steady unless a commit or a power-down occurs. A power-down always leaves the loop unselected. The lock flag is low whenever the loop is disabled, and it drops after every restart. In timer modes the lock flag does not fall until something restarts acquisition. Only the bench scenarios can show the rest: the exact unlock sequence and its abort cases, the pending and status readback values, and the exact timer lengths in both out-of-band modes.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  localparam int MULT_W = 15;
  localparam int DIV_W  = 8;
  localparam int DATA_W = 32;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_KEY  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RNG_TRUSTED = 2'd0,
    RNG_FAST    = 2'd1,
    RNG_SLOW    = 2'd2,
    RNG_SLOW_B  = 2'd3
  } ref_rng_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [DIV_W-1:0]  div;
    logic              en;
    logic              con;
  } clk_set_t;
endpackage

// File: rtl/clkmul_feed.sv
module clkmul_feed
  import clkmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_key,
  input  logic [7:0] key_byte,
  output logic       commit_o
);
  logic armed_q;

  assign commit_o = wr_en && wr_key && armed_q && (key_byte == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      armed_q <= wr_key && (key_byte == KEY_FIRST);
    end
  end
endmodule

// File: rtl/clkmul_settings.sv
module clkmul_settings
  import clkmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic [1:0]        ctrl_bits,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              commit,
  input  logic              pwr_down,
  output clk_set_t          pend_o,
  output clk_set_t          act_o,
  output logic              en_next_o,
  output logic              restart_o
);
  clk_set_t pend_q;
  clk_set_t act_q;
  clk_set_t act_d;

  always_comb begin
    act_d = act_q;
    if (commit) begin
      act_d = pend_q;
    end
    if (pwr_down) begin
      act_d.en  = 1'b0;
      act_d.con = 1'b0;
    end
  end

  assign restart_o = (act_d.mult != act_q.mult) ||
                     (act_d.div  != act_q.div)  ||
                     (act_d.en   != act_q.en);
  assign en_next_o = act_d.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      if (wr_ctrl) begin
        pend_q.en  <= ctrl_bits[0];
        pend_q.con <= ctrl_bits[1];
      end
      if (wr_cfg) begin
        pend_q.mult <= mult_in;
        pend_q.div  <= div_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else begin
      act_q <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/clkmul_lock.sv
module clkmul_lock
  import clkmul_pkg::*;
#(
  parameter int START_CYC = 50000,
  parameter int REF_CYC   = 200,
  parameter int REF_SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_next,
  input  logic       restart,
  input  logic       lock_in,
  input  logic [1:0] ref_range,
  input  logic       ref_clk,
  output logic       lock_o
);
  localparam int CNT_MAX = (START_CYC > REF_CYC) ? START_CYC : REF_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] REF_LAST   = CNT_W'(REF_CYC - 1);

  logic [REF_SYNC:0] ref_sh_q;
  logic              ref_rise;
  logic [CNT_W-1:0]  cnt_q;
  logic              lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh_q <= '0;
    end else begin
      ref_sh_q[0] <= ref_clk;
      for (int i = 1; i <= REF_SYNC; i++) begin
        ref_sh_q[i] <= ref_sh_q[i-1];
      end
    end
  end

  assign ref_rise = ref_sh_q[REF_SYNC-1] & ~ref_sh_q[REF_SYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (restart || !en_next) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      unique case (ref_rng_e'(ref_range))
        RNG_TRUSTED: lock_q <= lock_in;
        RNG_FAST: begin
          if (cnt_q >= START_LAST) lock_q <= 1'b1;
          else                     cnt_q  <= cnt_q + 1'b1;
        end
        default: begin
          if (ref_rise) begin
            if (cnt_q >= REF_LAST) lock_q <= 1'b1;
            else                   cnt_q  <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int START_CYC = 50000,
  parameter int REF_CYC   = 200,
  parameter int REF_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_down_req,
  input  logic [1:0]        ref_range,
  input  logic              ref_clk,
  input  logic              lock_in,
  output logic              pll_sel,
  output logic              lock_irq,
  output logic [MULT_W-1:0] act_mult,
  output logic [DIV_W-1:0]  act_div
);
  reg_sel_e          sel;
  logic              wr_ctrl, wr_cfg, wr_key;
  logic              commit_w, restart_w, en_next_w;
  logic              act_en_w, act_con_w;
  logic              lock_w;
  clk_set_t          pend_w, act_w;
  logic [DATA_W-1:0] stat_w, rd_mux;
  logic              unused_bits;

  assign sel     = reg_sel_e'(addr);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_cfg  = wr_en && (sel == SEL_CFG);
  assign wr_key  = (sel == SEL_KEY);
  assign unused_bits = ^{wdata[31:24], wdata[15]};

  clkmul_feed u_feed (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_key   (wr_key),
    .key_byte (wdata[7:0]),
    .commit_o (commit_w)
  );

  clkmul_settings u_set (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .wr_cfg    (wr_cfg),
    .ctrl_bits (wdata[1:0]),
    .mult_in   (wdata[MULT_W-1:0]),
    .div_in    (wdata[16 +: DIV_W]),
    .commit    (commit_w),
    .pwr_down  (pwr_down_req),
    .pend_o    (pend_w),
    .act_o     (act_w),
    .en_next_o (en_next_w),
    .restart_o (restart_w)
  );

  clkmul_lock #(
    .START_CYC (START_CYC),
    .REF_CYC   (REF_CYC),
    .REF_SYNC  (REF_SYNC)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .en_next   (en_next_w),
    .restart   (restart_w),
    .lock_in   (lock_in),
    .ref_range (ref_range),
    .ref_clk   (ref_clk),
    .lock_o    (lock_w)
  );

  assign act_en_w  = act_w.en;
  assign act_con_w = act_w.con;
  assign stat_w = {5'b0, lock_w, act_w.con, act_w.en, act_w.div, 1'b0, act_w.mult};

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = {30'b0, pend_w.con, pend_w.en};
      SEL_CFG:  rd_mux = {8'b0, pend_w.div, 1'b0, pend_w.mult};
      SEL_STAT: rd_mux = stat_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

  assign pll_sel  = act_en_w & act_con_w;
  assign lock_irq = lock_w;
  assign act_mult = act_w.mult;
  assign act_div  = act_w.div;
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk
  import clkmul_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pwr_down_req,
  input logic              commit_w,
  input logic              restart_w,
  input logic              act_en,
  input logic              pll_sel,
  input logic              lock_irq,
  input logic [1:0]        ref_range,
  input logic [MULT_W-1:0] act_mult,
  input logic [DIV_W-1:0]  act_div
);
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!commit_w && !pwr_down_req) |=> ($stable(act_mult) && $stable(act_div))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!commit_w && !pwr_down_req) |=> $stable(pll_sel)); // R5
  AST_PD_DESELECT: assert property (@(posedge clk) disable iff (rst)
    pwr_down_req |=> (!pll_sel && !act_en)); // R6
  AST_NO_LOCK_OFF: assert property (@(posedge clk) disable iff (rst)
    !act_en |-> !lock_irq); // R7
  AST_RESTART_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    restart_w |=> !lock_irq); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (lock_irq && !restart_w && !pwr_down_req && act_en && (ref_range != 2'd0)
     && !commit_w) |=> lock_irq); // R12
endmodule

bind clkmul_ctrl clkmul_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_down_req (pwr_down_req),
  .commit_w     (commit_w),
  .restart_w    (restart_w),
  .act_en       (act_en_w),
  .pll_sel      (pll_sel),
  .lock_irq     (lock_irq),
  .ref_range    (ref_range),
  .act_mult     (act_mult),
  .act_div      (act_div)
);

// File: tb/clkmul_ctrl_tb.sv
module clkmul_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int START_CYC  = 40;
  localparam int REF_CYC    = 6;
  localparam logic [1:0] A_CTRL = 2'd0, A_CFG = 2'd1, A_KEY = 2'd2, A_STAT = 2'd3;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        pwr_down_req = 1'b0, ref_clk = 1'b0, lock_in = 1'b0;
  logic [1:0]  ref_range = 2'd0;
  logic        pll_sel, lock_irq;
  logic [14:0] act_mult;
  logic [7:0]  act_div;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [14:0] m_pmult = '0, m_amult = '0;
  logic [7:0]  m_pdiv = '0, m_adiv = '0;
  logic        m_pen = 0, m_pcon = 0, m_aen = 0, m_acon = 0, m_armed = 0;

  clkmul_ctrl #(.START_CYC(START_CYC), .REF_CYC(REF_CYC), .REF_SYNC(2)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwr_down_req(pwr_down_req),
    .ref_range(ref_range), .ref_clk(ref_clk), .lock_in(lock_in),
    .pll_sel(pll_sel), .lock_irq(lock_irq), .act_mult(act_mult), .act_div(act_div)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(CLK_PERIOD*4) ref_clk = ~ref_clk;

  function automatic logic [31:0] exp_stat(input logic lk);
    return {5'b0, lk, m_acon, m_aen, m_adiv, 1'b0, m_amult};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [31:0] d);
    if (a == A_KEY) begin
      if (m_armed && d[7:0] == 8'h55) begin
        m_amult = m_pmult; m_adiv = m_pdiv; m_aen = m_pen; m_acon = m_pcon;
      end
      m_armed = (d[7:0] == 8'hAA);
    end else begin
      m_armed = 1'b0;
      if (a == A_CTRL) begin m_pen = d[0]; m_pcon = d[1]; end
      if (a == A_CFG)  begin m_pmult = d[14:0]; m_pdiv = d[23:16]; end
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic feed();
    bus_wr(A_KEY, 32'hAA);
    bus_wr(A_KEY, 32'h55);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog got=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    bus_rd(A_STAT, rd); check("R1 status", rd, 32'h0);
    bus_rd(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
    bus_rd(A_CFG, rd);  check("R1 cfg", rd, 32'h0);
    check("R1 pll_sel", {31'b0, pll_sel}, 32'h0);
    check("R1 lock_irq", {31'b0, lock_irq}, 32'h0);

    // R2 pending only
    bus_wr(A_CFG, 32'h0012_0034);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_STAT, rd); check("R2 status unchanged", rd, 32'h0);
    bus_rd(A_CFG, rd);  check("R2 cfg readback", rd, 32'h0012_0034);
    bus_rd(A_CTRL, rd); check("R2 ctrl readback", rd, 32'h3);

    // R3 aborted sequences
    bus_wr(A_KEY, 32'hAA); bus_wr(A_CTRL, 32'h3); bus_wr(A_KEY, 32'h55);
    bus_rd(A_STAT, rd); check("R3 intervening write aborts", rd, 32'h0);
    bus_wr(A_KEY, 32'hAA); bus_wr(A_KEY, 32'h56); bus_wr(A_KEY, 32'h55);
    bus_rd(A_STAT, rd); check("R3 wrong key aborts", rd, 32'h0);
    bus_wr(A_KEY, 32'hAA); bus_wr(A_STAT, 32'h0); bus_wr(A_KEY, 32'h55);
    bus_rd(A_STAT, rd); check("R3 status write aborts", rd, 32'h0);
    feed();
    bus_rd(A_STAT, rd); check("R3 R4 valid commit", rd, 32'h0312_0034);
    check("R4 act_mult port", {17'b0, act_mult}, 32'h34);
    check("R5 pll_sel both set", {31'b0, pll_sel}, 32'h1);

    // R7 and R12 lock follows input in trusted band
    @(negedge clk); lock_in = 1'b1;
    @(negedge clk); check("R7 lock follows input", {31'b0, lock_irq}, 32'h1);
    bus_rd(A_STAT, rd); check("R12 status bit 26", rd, exp_stat(1'b1));
    @(negedge clk); lock_in = 1'b0;
    @(negedge clk); check("R7 lock drops with input", {31'b0, lock_irq}, 32'h0);
    lock_in = 1'b1;
    @(negedge clk);

    // R10 restart rules
    feed();
    check("R10 same values keep lock", {31'b0, lock_irq}, 32'h1);
    bus_wr(A_CFG, 32'h0012_0035);
    feed();
    check("R10 new multiplier clears lock", {31'b0, lock_irq}, 32'h0);
    @(negedge clk); check("R10 lock reacquired", {31'b0, lock_irq}, 32'h1);

    // R6 power-down
    @(negedge clk); pwr_down_req = 1'b1;
    @(negedge clk); pwr_down_req = 1'b0; m_aen = 0; m_acon = 0;
    check("R6 pll_sel off", {31'b0, pll_sel}, 32'h0);
    check("R6 R7 lock off when disabled", {31'b0, lock_irq}, 32'h0);
    bus_rd(A_STAT, rd); check("R6 status en/con clear", rd, exp_stat(1'b0));
    bus_rd(A_CTRL, rd); check("R6 pending kept", rd, 32'h3);
    bus_wr(A_KEY, 32'hAA);
    @(negedge clk); wr_en = 1'b1; addr = A_KEY; wdata = 32'h55; pwr_down_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; pwr_down_req = 1'b0; m_armed = 0;
    check("R6 power-down beats commit", {31'b0, pll_sel}, 32'h0);
    feed();
    check("R5 reselected after commit", {31'b0, pll_sel}, 32'h1);

    // R11 status write ignored, key reads zero
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, rd); check("R11 status write ignored", rd, exp_stat(lock_irq));
    bus_rd(A_KEY, rd);  check("R11 key reads zero", rd, 32'h0);

    // R8 fast-reference timer
    lock_in = 1'b0; ref_range = 2'd1;
    bus_wr(A_CTRL, 32'h0); feed();
    bus_wr(A_CTRL, 32'h3); feed();
    repeat (START_CYC-1) @(negedge clk);
    check("R8 not locked before timeout", {31'b0, lock_irq}, 32'h0);
    @(negedge clk); check("R8 locked at timeout", {31'b0, lock_irq}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 R12 lock held", {31'b0, lock_irq}, 32'h1);

    // R9 slow-reference edge count
    ref_range = 2'd2;
    bus_wr(A_CTRL, 32'h0); feed();
    bus_wr(A_CTRL, 32'h3); feed();
    repeat (32) @(negedge clk);
    check("R9 not locked early", {31'b0, lock_irq}, 32'h0);
    repeat (40) @(negedge clk);
    check("R9 locked after edge count", {31'b0, lock_irq}, 32'h1);

    // Random phase: R2 R3 R4 R5 R11
    ref_range = 2'd0; lock_in = 1'b0;
    repeat (3) @(negedge clk);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: bus_wr(A_CTRL, $urandom);
        1: bus_wr(A_CFG, $urandom & 32'h00FF_7FFF);
        2: bus_wr(A_KEY, 32'hAA);
        3: bus_wr(A_KEY, 32'h55);
        4: bus_wr(A_KEY, $urandom & 32'hFF);
        5: bus_wr(A_STAT, $urandom);
        6: begin
          bus_rd(A_CFG, rd);
          check("R2 random cfg readback", rd, {8'b0, m_pdiv, 1'b0, m_pmult});
        end
        default: begin
          bus_rd(A_STAT, rd);
          check("R4 random status", rd, exp_stat(1'b0));
        end
      endcase
      check("R5 random pll_sel", {31'b0, pll_sel}, {31'b0, m_aen & m_acon});
    end

    done = 1'b1;
    finish_run();
  end
endmodule